// File: doc/BRIEF.md
# Packed Alternating-Sign Fused Multiply-Add Lane Controller

This block sits in front of an array of per-lane single-precision fused multiply-add units and behind the register file of a vector pipeline. It accepts one packed operation at a time: a destination vector (which is also a source), two more source vectors, a selector for one of three operand orderings, a vector length, a writemask with its masking style, a broadcast flag and two rounding-mode candidates. For every 32-bit lane it presents a multiplicand, a multiplier and an addend to the lane units. Even lanes have the addend's sign bit inverted, so those lanes yield product minus addend while odd lanes yield product plus addend. The lane units themselves only add.

When the lane units hand back their results and exception flags, the block merges each lane into the destination according to the writemask. Lanes beyond the active length are forced to zero. It ORs the flags of the lanes that were really written into a sticky five-bit status. The arithmetic is outside the block. Inputs and outputs use a valid/ready handshake, and the block holds one operation at a time.

Top module: `alt_fma_lane_ctrl`

## Requirements
- R1: On every active lane the addend reaches the lane port with bit 31 inverted on even lanes (lane 0 is even) and unchanged on odd lanes; multiplicand and multiplier pass unchanged.
- R2: Form code 0 presents destination as multiplicand, source 3 as multiplier and source 2 as addend.
- R3: Form code 1 presents source 2 as multiplicand, destination as multiplier and source 3 as addend.
- R4: Form code 2 presents source 2 as multiplicand, source 3 as multiplier and destination as addend; form code 3 behaves exactly as code 2.
- R5: Length code 0, 1, 2 gives 4, 8, 16 active lanes (code 3 acts as 16); every result bit in a lane at or above the active count is zero.
- R6: With the broadcast flag set and source 3 marked as memory, bits 31:0 of source 3 replace source 3 in every lane; with source 3 marked as a register the broadcast flag leaves the operands untouched.
- R7: With masking disabled every active lane takes its lane result regardless of the mask; with masking enabled a lane whose mask bit is 0 keeps its old destination value when the zero-mask flag is 0 and becomes zero when it is 1.
- R8: The rounding mode sent to the lanes is the embedded one only when the length is 16 lanes, the broadcast flag is 1 and source 3 is a register; otherwise it is the control-register one.
- R9: The status output ORs in the five-bit flags of active lanes that are written (not masked off) when results return, never clears except at reset, and is zero after reset.
- R10: After reset in_ready is 1 and out_valid and lane_valid are 0; an accepted operation raises lane_valid and holds its operands until lane_done; out_valid rises the cycle after lane_done and holds with stable data until out_ready, and in_ready stays 0 meanwhile.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Block idle and able to accept |
| in_form | input | 2 | Operand ordering code |
| in_vlen | input | 2 | Vector length code |
| in_dst | input | 512 | Destination / first source |
| in_src2 | input | 512 | Second source |
| in_src3 | input | 512 | Third source |
| in_src3_mem | input | 1 | Third source came from memory |
| in_bcast | input | 1 | Broadcast / embedded-rounding flag |
| in_mask_en | input | 1 | Apply writemask |
| in_zero_mask | input | 1 | Masked lanes become zero instead of kept |
| in_wmask | input | 16 | Per-lane write enable |
| in_rm_embed | input | 2 | Rounding mode carried by the operation |
| in_rm_ctrl | input | 2 | Rounding mode from the control register |
| lane_valid | output | 1 | Operands presented to the lane units |
| lane_mul_a | output | 512 | Per-lane multiplicand |
| lane_mul_b | output | 512 | Per-lane multiplier |
| lane_add_c | output | 512 | Per-lane addend, sign-adjusted |
| lane_rm | output | 2 | Rounding mode for the lane units |
| lane_done | input | 1 | Lane results valid |
| lane_res | input | 512 | Per-lane results |
| lane_flags | input | 80 | Five flags per lane |
| out_valid | output | 1 | Merged result available |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | 512 | Merged, length-trimmed result |
| status | output | 5 | Sticky OR of written lanes' flags |

## Verification
A wrong operand-mux or sign-flip state shows on the lane ports while lane_valid is high, and shows in out_data one cycle after lane_done, because the bench's stub folds the routed operands into each lane result. A wrong length or mask decision shows as a non-zero upper lane or a wrongly kept lane in that same output beat. A stale or leaky status bit appears in the status port on the cycle the result is loaded, and the first operation after reset is chosen so that it exposes flags from masked-off lanes. A stuck handshake state is caught within a few cycles by counting lane_valid cycles before out_valid and by the checks made while out_ready is held low.

// File: rtl/alt_fma_pkg.sv
package alt_fma_pkg;

   typedef enum logic [1:0] {
      FORM_DST_X_S3_P_S2 = 2'd0,
      FORM_S2_X_DST_P_S3 = 2'd1,
      FORM_S2_X_S3_P_DST = 2'd2,
      FORM_ALIAS_2       = 2'd3
   } form_e;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_ISSUE = 2'd1,
      ST_DONE  = 2'd2
   } state_e;

   // Active lane count for a length code, capped by the array size.
   function automatic int unsigned lanes_for(input logic [1:0] vl, input int unsigned max_lanes);
      int unsigned n;
      n = (vl == 2'd0) ? 4 : (vl == 2'd1) ? 8 : 16;
      return (n > max_lanes) ? max_lanes : n;
   endfunction

endpackage

// File: rtl/alt_fma_route.sv
module alt_fma_route
   import alt_fma_pkg::*;
#(
   parameter int LANES  = 16,
   parameter int LANE_W = 32
) (
   input  logic [1:0]              form,
   input  logic                    bcast_mem,
   input  logic [LANES*LANE_W-1:0] dst,
   input  logic [LANES*LANE_W-1:0] src2,
   input  logic [LANES*LANE_W-1:0] src3,
   output logic [LANES*LANE_W-1:0] mul_a,
   output logic [LANES*LANE_W-1:0] mul_b,
   output logic [LANES*LANE_W-1:0] add_c
);
   localparam logic [LANE_W-1:0] SIGN = {1'b1, {(LANE_W-1){1'b0}}};

   for (genvar j = 0; j < LANES; j++) begin : g_lane
      logic [LANE_W-1:0] d_l, s2_l, s3_l, a_l, b_l, c_l;
      assign d_l  = dst[j*LANE_W +: LANE_W];
      assign s2_l = src2[j*LANE_W +: LANE_W];
      assign s3_l = bcast_mem ? src3[LANE_W-1:0] : src3[j*LANE_W +: LANE_W];

      always_comb begin
         unique case (form_e'(form))
            FORM_DST_X_S3_P_S2: begin a_l = d_l;  b_l = s3_l; c_l = s2_l; end
            FORM_S2_X_DST_P_S3: begin a_l = s2_l; b_l = d_l;  c_l = s3_l; end
            default:            begin a_l = s2_l; b_l = s3_l; c_l = d_l;  end
         endcase
      end

      assign mul_a[j*LANE_W +: LANE_W] = a_l;
      assign mul_b[j*LANE_W +: LANE_W] = b_l;
      if ((j % 2) == 0) begin : g_even
         assign add_c[j*LANE_W +: LANE_W] = c_l ^ SIGN;
      end else begin : g_odd
         assign add_c[j*LANE_W +: LANE_W] = c_l;
      end
   end
endmodule

// File: rtl/alt_fma_merge.sv
module alt_fma_merge #(
   parameter int LANES  = 16,
   parameter int LANE_W = 32,
   parameter int FLAG_W = 5
) (
   input  logic [LANES-1:0]        active,
   input  logic [LANES-1:0]        wmask,
   input  logic                    mask_en,
   input  logic                    zero_mask,
   input  logic [LANES*LANE_W-1:0] old_dst,
   input  logic [LANES*LANE_W-1:0] res,
   input  logic [LANES*FLAG_W-1:0] flags,
   output logic [LANES*LANE_W-1:0] merged,
   output logic [FLAG_W-1:0]       flag_or
);
   logic [LANES-1:0] write_en;
   assign write_en = active & (mask_en ? wmask : {LANES{1'b1}});

   always_comb begin
      flag_or = '0;
      for (int j = 0; j < LANES; j++) begin
         if (!active[j])
            merged[j*LANE_W +: LANE_W] = '0;
         else if (write_en[j])
            merged[j*LANE_W +: LANE_W] = res[j*LANE_W +: LANE_W];
         else if (zero_mask)
            merged[j*LANE_W +: LANE_W] = '0;
         else
            merged[j*LANE_W +: LANE_W] = old_dst[j*LANE_W +: LANE_W];
         if (write_en[j])
            flag_or = flag_or | flags[j*FLAG_W +: FLAG_W];
      end
   end
endmodule

// File: rtl/alt_fma_rm_sel.sv
module alt_fma_rm_sel #(
   parameter int RM_W = 2
) (
   input  logic            full_len,
   input  logic            bcast,
   input  logic            src3_mem,
   input  logic [RM_W-1:0] rm_embed,
   input  logic [RM_W-1:0] rm_ctrl,
   output logic [RM_W-1:0] rm_out
);
   logic use_embed;
   assign use_embed = full_len & bcast & ~src3_mem;
   assign rm_out    = use_embed ? rm_embed : rm_ctrl;
endmodule

// File: rtl/alt_fma_lane_ctrl.sv
module alt_fma_lane_ctrl
   import alt_fma_pkg::*;
#(
   parameter int MAX_LANES = 16,
   parameter int LANE_W    = 32,
   parameter int FLAG_W    = 5,
   parameter int RM_W      = 2
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          in_valid,
   output logic                          in_ready,
   input  logic [1:0]                    in_form,
   input  logic [1:0]                    in_vlen,
   input  logic [MAX_LANES*LANE_W-1:0]   in_dst,
   input  logic [MAX_LANES*LANE_W-1:0]   in_src2,
   input  logic [MAX_LANES*LANE_W-1:0]   in_src3,
   input  logic                          in_src3_mem,
   input  logic                          in_bcast,
   input  logic                          in_mask_en,
   input  logic                          in_zero_mask,
   input  logic [MAX_LANES-1:0]          in_wmask,
   input  logic [RM_W-1:0]               in_rm_embed,
   input  logic [RM_W-1:0]               in_rm_ctrl,
   output logic                          lane_valid,
   output logic [MAX_LANES*LANE_W-1:0]   lane_mul_a,
   output logic [MAX_LANES*LANE_W-1:0]   lane_mul_b,
   output logic [MAX_LANES*LANE_W-1:0]   lane_add_c,
   output logic [RM_W-1:0]               lane_rm,
   input  logic                          lane_done,
   input  logic [MAX_LANES*LANE_W-1:0]   lane_res,
   input  logic [MAX_LANES*FLAG_W-1:0]   lane_flags,
   output logic                          out_valid,
   input  logic                          out_ready,
   output logic [MAX_LANES*LANE_W-1:0]   out_data,
   output logic [FLAG_W-1:0]             status
);
   localparam int VEC_W = MAX_LANES * LANE_W;
   localparam int MIN_W = 4 * LANE_W;

   if (MAX_LANES != 4 && MAX_LANES != 8 && MAX_LANES != 16) begin : g_bad_lanes
      $error("MAX_LANES must be 4, 8 or 16");
   end
   if (LANE_W < 2) begin : g_bad_width
      $error("LANE_W must hold a sign bit and a magnitude");
   end
   if (FLAG_W < 1 || RM_W < 1) begin : g_bad_ctrl
      $error("FLAG_W and RM_W must be positive");
   end

   state_e                 st;
   logic [VEC_W-1:0]       dst_q, s2_q, s3_q, out_q;
   logic [1:0]             form_q, vlen_q;
   logic                   mem_q, bcast_q, mask_en_q, zero_q;
   logic [MAX_LANES-1:0]   wmask_q, active;
   logic [RM_W-1:0]        rme_q, rmc_q;
   logic [FLAG_W-1:0]      status_q, flag_or;
   logic [VEC_W-1:0]       merged;

   assign in_ready   = (st == ST_IDLE);
   assign lane_valid = (st == ST_ISSUE);
   assign out_valid  = (st == ST_DONE);
   assign out_data   = out_q;
   assign status     = status_q;

   always_comb begin
      for (int j = 0; j < MAX_LANES; j++)
         active[j] = (j < int'(lanes_for(vlen_q, MAX_LANES)));
   end

   alt_fma_route #(.LANES(MAX_LANES), .LANE_W(LANE_W)) u_route (
      .form      (form_q),
      .bcast_mem (bcast_q & mem_q),
      .dst       (dst_q),
      .src2      (s2_q),
      .src3      (s3_q),
      .mul_a     (lane_mul_a),
      .mul_b     (lane_mul_b),
      .add_c     (lane_add_c)
   );

   alt_fma_rm_sel #(.RM_W(RM_W)) u_rm (
      .full_len  (vlen_q[1]),
      .bcast     (bcast_q),
      .src3_mem  (mem_q),
      .rm_embed  (rme_q),
      .rm_ctrl   (rmc_q),
      .rm_out    (lane_rm)
   );

   alt_fma_merge #(.LANES(MAX_LANES), .LANE_W(LANE_W), .FLAG_W(FLAG_W)) u_merge (
      .active    (active),
      .wmask     (wmask_q),
      .mask_en   (mask_en_q),
      .zero_mask (zero_q),
      .old_dst   (dst_q),
      .res       (lane_res),
      .flags     (lane_flags),
      .merged    (merged),
      .flag_or   (flag_or)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st <= ST_IDLE;
         dst_q <= '0; s2_q <= '0; s3_q <= '0; out_q <= '0;
         form_q <= '0; vlen_q <= '0; mem_q <= 1'b0; bcast_q <= 1'b0;
         mask_en_q <= 1'b0; zero_q <= 1'b0; wmask_q <= '0;
         rme_q <= '0; rmc_q <= '0; status_q <= '0;
      end else begin
         unique case (st)
            ST_IDLE: if (in_valid) begin
               dst_q <= in_dst; s2_q <= in_src2; s3_q <= in_src3;
               form_q <= in_form; vlen_q <= in_vlen;
               mem_q <= in_src3_mem; bcast_q <= in_bcast;
               mask_en_q <= in_mask_en; zero_q <= in_zero_mask; wmask_q <= in_wmask;
               rme_q <= in_rm_embed; rmc_q <= in_rm_ctrl;
               st <= ST_ISSUE;
            end
            ST_ISSUE: if (lane_done) begin
               out_q    <= merged;
               status_q <= status_q | flag_or;
               st       <= ST_DONE;
            end
            ST_DONE: if (out_ready) st <= ST_IDLE;
            default: st <= ST_IDLE;
         endcase
      end
   end

   // R10: one operation in flight; no acceptance while busy
   p_busy_blocks_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid || lane_valid) |-> !in_ready);

   // R10: operands held until the lanes answer
   p_lane_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (lane_valid && !lane_done) |=> (lane_valid && $stable(lane_mul_a)
                                      && $stable(lane_add_c) && $stable(lane_rm)));

   // R10: result held until taken
   p_out_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

   // R9: status bits never fall
   p_status_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((status & $past(status)) == $past(status)));

   // R5: shortest length leaves upper lanes zero
   if (MAX_LANES > 4) begin : g_upper_chk
      p_upper_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
         (out_valid && vlen_q == 2'd0) |-> (out_data[VEC_W-1:MIN_W] == '0));
   end
endmodule

// File: tb/alt_fma_lane_ctrl_tb.sv
`timescale 1ns/1ps
module alt_fma_lane_ctrl_tb;
   localparam int L = 16;
   localparam int W = 32;
   localparam int VW = L*W;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   logic in_valid = 0, in_src3_mem = 0, in_bcast = 0, in_mask_en = 0, in_zero_mask = 0;
   logic [1:0] in_form = 0, in_vlen = 0, in_rm_embed = 0, in_rm_ctrl = 0;
   logic [VW-1:0] in_dst = '0, in_src2 = '0, in_src3 = '0;
   logic [L-1:0] in_wmask = '0;
   logic in_ready, lane_valid, lane_done, out_valid;
   logic out_ready = 0;
   logic [VW-1:0] lane_mul_a, lane_mul_b, lane_add_c, lane_res, out_data;
   logic [1:0] lane_rm;
   logic [L*5-1:0] stub_flags;
   logic [4:0] status;

   int total = 0, bad = 0;
   int ret_delay = 0;
   int vcnt = 0;
   int cycles = 0;

   // Integer loopback stub for the lane units
   always @(posedge clk) vcnt <= lane_valid ? vcnt + 1 : 0;
   assign lane_done = lane_valid && (vcnt >= ret_delay);
   for (genvar j = 0; j < L; j++) begin : g_stub
      assign lane_res[j*W +: W] = lane_mul_a[j*W +: W] * lane_mul_b[j*W +: W] + lane_add_c[j*W +: W];
   end

   alt_fma_lane_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .in_form(in_form), .in_vlen(in_vlen), .in_dst(in_dst), .in_src2(in_src2),
      .in_src3(in_src3), .in_src3_mem(in_src3_mem), .in_bcast(in_bcast),
      .in_mask_en(in_mask_en), .in_zero_mask(in_zero_mask), .in_wmask(in_wmask),
      .in_rm_embed(in_rm_embed), .in_rm_ctrl(in_rm_ctrl), .lane_valid(lane_valid),
      .lane_mul_a(lane_mul_a), .lane_mul_b(lane_mul_b), .lane_add_c(lane_add_c),
      .lane_rm(lane_rm), .lane_done(lane_done), .lane_res(lane_res),
      .lane_flags(stub_flags), .out_valid(out_valid), .out_ready(out_ready),
      .out_data(out_data), .status(status)
   );

   logic [4:0] exp_status = '0;
   int last_wait;

   task automatic chk(input bit ok, input string req, input logic [VW-1:0] act, input logic [VW-1:0] expv);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, expv);
      end
   endtask

   // Run one operation and check everything the requirements predict.
   task automatic do_op(input string req);
      logic [VW-1:0] expv;
      logic [1:0] exp_rm, cap_rm;
      logic [W-1:0] d, s2, s3, a, b, c;
      logic [4:0] fl;
      int n, nl;
      logic [VW-1:0] held;
      nl = (in_vlen == 0) ? 4 : (in_vlen == 1) ? 8 : 16;
      fl = '0;
      for (int j = 0; j < L; j++) begin
         d  = in_dst[j*W +: W];
         s2 = in_src2[j*W +: W];
         s3 = (in_bcast && in_src3_mem) ? in_src3[W-1:0] : in_src3[j*W +: W];
         case (in_form)
            2'd0: begin a = d;  b = s3; c = s2; end
            2'd1: begin a = s2; b = d;  c = s3; end
            default: begin a = s2; b = s3; c = d; end
         endcase
         if (j % 2 == 0) c = c ^ 32'h8000_0000;
         if (j >= nl) expv[j*W +: W] = '0;
         else if (in_mask_en && !in_wmask[j]) expv[j*W +: W] = in_zero_mask ? '0 : d;
         else begin
            expv[j*W +: W] = a * b + c;
            fl = fl | stub_flags[j*5 +: 5];
         end
      end
      exp_status = exp_status | fl;
      exp_rm = (in_vlen >= 2 && in_bcast && !in_src3_mem) ? in_rm_embed : in_rm_ctrl;
      cap_rm = 2'bxx;
      in_valid = 1;
      @(negedge clk);
      in_valid = 0;
      n = 0;
      while (!out_valid && n < 60) begin
         if (lane_valid) cap_rm = lane_rm;
         n++;
         @(negedge clk);
      end
      last_wait = n;
      chk(out_valid, {req, " R10 out_valid"}, VW'(out_valid), VW'(1));
      chk(out_data === expv, {req, " result"}, out_data, expv);
      chk(status === exp_status, {req, " R9 status"}, VW'(status), VW'(exp_status));
      chk(cap_rm === exp_rm, {req, " R8 rounding"}, VW'(cap_rm), VW'(exp_rm));
      held = out_data;
      repeat (2) @(negedge clk);
      chk(out_valid && !in_ready && out_data === held, {req, " R10 hold"}, out_data, held);
      out_ready = 1;
      @(negedge clk);
      out_ready = 0;
      chk(in_ready && !out_valid, {req, " R10 idle"}, VW'(in_ready), VW'(1));
   endtask

   task automatic fill_random();
      for (int j = 0; j < L; j++) begin
         in_dst[j*W +: W]  = $urandom;
         in_src2[j*W +: W] = $urandom;
         in_src3[j*W +: W] = $urandom;
      end
   endtask

   task automatic plain(input logic [1:0] f, input logic [1:0] v);
      in_form = f; in_vlen = v; in_mask_en = 0; in_zero_mask = 0;
      in_bcast = 0; in_src3_mem = 0; in_wmask = '0;
   endtask

   task automatic t_reset_r10();
      chk(in_ready && !out_valid && !lane_valid && status == 0, "R10 reset state",
          VW'({in_ready, out_valid, lane_valid, status}), VW'(8'h80));
   endtask

   task automatic t_status_r9();
      for (int j = 0; j < L; j++) stub_flags[j*5 +: 5] = 5'b11110;
      stub_flags[4:0] = 5'b00001;
      fill_random(); plain(2'd0, 2'd0);
      in_mask_en = 1; in_wmask = 16'hFFF1;
      do_op("R9 masked-off flags excluded");
      chk(status == 5'b00001, "R9 only lane0 flags", VW'(status), VW'(5'b00001));
      for (int j = 0; j < L; j++) stub_flags[j*5 +: 5] = 5'(1 << (j % 5));
   endtask

   task automatic t_forms_r1_r2_r3_r4();
      fill_random(); plain(2'd0, 2'd2); do_op("R2 R1 form0");
      fill_random(); plain(2'd1, 2'd2); do_op("R3 R1 form1");
      fill_random(); plain(2'd2, 2'd2); do_op("R4 R1 form2");
      fill_random(); plain(2'd3, 2'd2); do_op("R4 form3 alias");
      // lane-port sign check, zero multiplicand
      in_dst = '0; in_src2 = {L{32'h0000_0005}}; in_src3 = {L{32'h1234_5678}};
      plain(2'd0, 2'd2); do_op("R1 sign flip only on even lanes");
      chk(out_data[31:0] == 32'h8000_0005 && out_data[63:32] == 32'h0000_0005,
          "R1 lanes 0/1", VW'(out_data[63:0]), VW'(64'h0000_0005_8000_0005));
   endtask

   task automatic t_len_r5();
      fill_random(); plain(2'd2, 2'd0); do_op("R5 len4");
      fill_random(); plain(2'd1, 2'd1); do_op("R5 len8");
      chk(out_data[VW-1:256] == '0, "R5 upper zero len8", out_data, '0);
      fill_random(); plain(2'd0, 2'd3); do_op("R5 len code3");
   endtask

   task automatic t_bcast_r6();
      fill_random(); plain(2'd0, 2'd2); in_bcast = 1; in_src3_mem = 1; do_op("R6 bcast mem form0");
      fill_random(); plain(2'd1, 2'd1); in_bcast = 1; in_src3_mem = 1; do_op("R6 bcast mem form1");
      fill_random(); plain(2'd2, 2'd2); in_bcast = 1; in_src3_mem = 0; do_op("R6 bcast reg ignored");
   endtask

   task automatic t_mask_r7();
      fill_random(); plain(2'd0, 2'd2); in_mask_en = 1; in_wmask = 16'hA5C3; do_op("R7 merge");
      fill_random(); plain(2'd2, 2'd2); in_mask_en = 1; in_zero_mask = 1; in_wmask = 16'h5A3C; do_op("R7 zero");
      fill_random(); plain(2'd1, 2'd2); in_mask_en = 0; in_zero_mask = 1; in_wmask = 16'h0000; do_op("R7 mask disabled");
   endtask

   task automatic t_round_r8();
      in_rm_embed = 2'b11; in_rm_ctrl = 2'b01;
      fill_random(); plain(2'd0, 2'd2); in_bcast = 1; in_src3_mem = 0; do_op("R8 embedded");
      fill_random(); plain(2'd0, 2'd1); in_bcast = 1; in_src3_mem = 0; do_op("R8 len8 ctrl");
      fill_random(); plain(2'd0, 2'd2); in_bcast = 1; in_src3_mem = 1; do_op("R8 mem ctrl");
      fill_random(); plain(2'd0, 2'd2); in_bcast = 0; in_src3_mem = 0; do_op("R8 no flag ctrl");
      in_rm_embed = 2'b00; in_rm_ctrl = 2'b10;
   endtask

   task automatic t_latency_r10();
      fill_random(); plain(2'd2, 2'd2);
      ret_delay = 0; do_op("R10 immediate");
      chk(last_wait == 1, "R10 latency d0", VW'(last_wait), VW'(1));
      ret_delay = 3; fill_random(); do_op("R10 delayed");
      chk(last_wait == 4, "R10 latency d3", VW'(last_wait), VW'(4));
      ret_delay = 0;
   endtask

   initial begin
      for (int j = 0; j < L; j++) stub_flags[j*5 +: 5] = 5'(1 << (j % 5));
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      t_reset_r10();
      t_status_r9();
      t_forms_r1_r2_r3_r4();
      t_len_r5();
      t_bcast_r6();
      t_mask_r7();
      t_round_r8();
      t_latency_r10();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000) begin
         total++; bad++;
         $display("FAIL watchdog actual=%0d expected=<100000", cycles);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule